// File: doc/BRIEF.md
# Append Queue with Randomized Drain

A memory module's secure buffer keeps a local stash of blocks. Other modules send it blocks through append messages. Some of those messages carry a real block and some are dummies, sent only to hide the real destination. This block is the bounded first-in first-out queue that holds the real blocks until they can enter the stash. Dummies are dropped at the door.

The queue empties through two paths.

- **Vacancy path.** When a local block leaves the stash for another module, the caller pulses a vacancy input. The oldest queued block then takes the freed stash slot, so stash occupancy stays the same.
- **Tree path.** On every access slot, a 16-bit LFSR draws a byte. If that byte is below a programmable 8-bit threshold, the queue asks the tree engine for one extra local access, which writes the oldest block into the tree. A nonzero threshold keeps the queue's utilization below one.

When the queue is full and a real block is offered, the queue refuses the block and forces an extra tree access, so the next offer is accepted. The stash and the tree engine are outside this block.

Top module: `migr_queue`

## Requirements
- R1: An append with app_dummy_i high is discarded. It changes neither the occupancy nor any output.
- R2: An append with app_valid_i high and app_dummy_i low, offered while the queue is not full, is stored. Occupancy rises by one on the next clock edge.
- R3: A vacancy pulse with a nonempty queue removes the oldest block. On the following cycle stash_valid_o is high and out_block_o carries that block, in arrival order. A vacancy pulse on an empty queue does nothing.
- R4: A probabilistic tree request is raised only on a cycle after slot_i was high with a nonempty queue and the LFSR byte was below prob_thr_i. A threshold of 0 never raises one.
- R5: The rate of probabilistic tree requests tracks prob_thr_i/256. With a threshold of 64 over 1024 slots with a nonempty queue, the count lies between 160 and 352.
- R6: When occupancy equals DEPTH, full_o is high and app_ready_o is low, and a real append is not stored. Occupancy never exceeds DEPTH.
- R7: A real append offered while the queue is full, with no vacancy in that cycle, causes tree_req_o on the next cycle with the oldest block. This happens whatever slot_i and prob_thr_i are.
- R8: When a vacancy and a probabilistic drain fall in the same cycle, only the vacancy path is served. stash_valid_o is high, tree_req_o is low, and occupancy drops by one.
- R9: An enqueue and a dequeue in the same cycle leave the occupancy unchanged.
- R10: After reset, occupancy is 0, full_o, stash_valid_o and tree_req_o are low, and app_ready_o is high.
- R11: stash_valid_o and tree_req_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| app_valid_i | input | 1 | Append message present |
| app_dummy_i | input | 1 | Append carries a dummy block |
| app_block_i | input | BLOCK_W | Appended block |
| app_ready_o | output | 1 | Queue can accept a real block |
| vacancy_i | input | 1 | A local block left the stash this cycle |
| slot_i | input | 1 | Access slot tick |
| prob_thr_i | input | 8 | Drain probability threshold, in units of 1/256 |
| stash_valid_o | output | 1 | out_block_o moves into the stash this cycle |
| tree_req_o | output | 1 | Extra tree access requested for out_block_o |
| out_block_o | output | BLOCK_W | Block leaving the queue |
| count_o | output | $clog2(DEPTH+1) | Occupancy |
| full_o | output | 1 | Occupancy equals DEPTH |

## Verification
The assertions check four things on every cycle:

- dummy appends never push;
- the queue neither overflows nor underflows;
- a vacancy wins over a random drain, and the two output strobes never coincide;
- a full queue with a pending real block forces a tree request, and a zero threshold never raises a random one.

The bench's scenarios are needed for the rest. It checks arrival-order delivery of block values through both exits, that a refused block is accepted on retry, and the measured drain rate for a given threshold. It also predicts the exact occupancy after mixed streams, and checks that a vacancy on an empty queue does nothing.

// File: rtl/migr_pkg.sv
package migr_pkg;
  localparam int unsigned LFSR_W   = 16;
  localparam int unsigned THR_W    = 8;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  typedef enum logic [1:0] {
    DEQ_NONE  = 2'd0,
    DEQ_STASH = 2'd1,
    DEQ_TREE  = 2'd2
  } deq_sel_e;
endpackage

// File: rtl/migr_lfsr.sv
module migr_lfsr
  import migr_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [THR_W-1:0] draw_o
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_d;

  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ LFSR_TAPS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= (SEED == '0) ? 16'h0001 : SEED;
    else if (step_i) state_q <= state_d;
  end

  assign draw_o = state_q[THR_W-1:0];

  // a Galois LFSR must never fall into the all-zero lockup state
  assert_lfsr_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/migr_fifo.sv
module migr_fifo #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned BLOCK_W = 64,
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [BLOCK_W-1:0] din_i,
  input  logic               pop_i,
  output logic [BLOCK_W-1:0] head_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               full_o,
  output logic               empty_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_C  = PTR_W'(DEPTH - 1);

  logic [BLOCK_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]   wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]   cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_C) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == DEPTH_C);
  assign empty_o = (cnt_q == '0);

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_enq_deq_same_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(count_o));
  assert_count_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= DEPTH_C);
endmodule

// File: rtl/migr_drain_ctl.sv
module migr_drain_ctl
  import migr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             app_valid_i,
  input  logic             app_dummy_i,
  input  logic             vacancy_i,
  input  logic             slot_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [THR_W-1:0] draw_i,
  input  logic             full_i,
  input  logic             empty_i,
  output logic             push_o,
  output logic             pop_o,
  output logic             stash_valid_o,
  output logic             tree_req_o
);
  logic     real_app, forced, lucky;
  deq_sel_e sel;

  assign real_app = app_valid_i && !app_dummy_i;
  assign push_o   = real_app && !full_i;
  assign forced   = real_app && full_i;
  assign lucky    = slot_i && (draw_i < thr_i);

  // vacancy path outranks both tree drains
  always_comb begin
    sel = DEQ_NONE;
    if (!empty_i) begin
      if (vacancy_i)            sel = DEQ_STASH;
      else if (forced || lucky) sel = DEQ_TREE;
    end
  end

  assign pop_o = (sel != DEQ_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stash_valid_o <= 1'b0;
      tree_req_o    <= 1'b0;
    end else begin
      stash_valid_o <= (sel == DEQ_STASH);
      tree_req_o    <= (sel == DEQ_TREE);
    end
  end

  assert_dummy_dropped_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (app_valid_i && app_dummy_i) |-> !push_o);
  assert_vacancy_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vacancy_i && !empty_i) |=> (stash_valid_o && !tree_req_o));
  assert_forced_drain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (real_app && full_i && !vacancy_i) |=> tree_req_o);
  assert_thr_zero_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_i == '0 && !(real_app && full_i)) |=> !tree_req_o);
  assert_one_exit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stash_valid_o && tree_req_o));
endmodule

// File: rtl/migr_queue.sv
module migr_queue
  import migr_pkg::*;
#(
  parameter int unsigned       DEPTH     = 16,
  parameter int unsigned       BLOCK_W   = 64,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int unsigned      CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               app_valid_i,
  input  logic               app_dummy_i,
  input  logic [BLOCK_W-1:0] app_block_i,
  output logic               app_ready_o,
  input  logic               vacancy_i,
  input  logic               slot_i,
  input  logic [THR_W-1:0]   prob_thr_i,
  output logic               stash_valid_o,
  output logic               tree_req_o,
  output logic [BLOCK_W-1:0] out_block_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               full_o
);
  logic               push, pop, full, empty;
  logic [BLOCK_W-1:0] head;
  logic [THR_W-1:0]   draw;
  logic [BLOCK_W-1:0] out_q;

  migr_fifo #(.DEPTH(DEPTH), .BLOCK_W(BLOCK_W)) i_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .din_i(app_block_i), .pop_i(pop),
    .head_o(head), .count_o(count_o), .full_o(full), .empty_o(empty)
  );

  migr_lfsr #(.SEED(LFSR_SEED)) i_lfsr (
    .clk_i, .rst_ni, .step_i(slot_i), .draw_o(draw)
  );

  migr_drain_ctl i_ctl (
    .clk_i, .rst_ni,
    .app_valid_i, .app_dummy_i, .vacancy_i, .slot_i,
    .thr_i(prob_thr_i), .draw_i(draw),
    .full_i(full), .empty_i(empty),
    .push_o(push), .pop_o(pop),
    .stash_valid_o(stash_valid_o), .tree_req_o(tree_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  out_q <= '0;
    else if (pop) out_q <= head;
  end

  assign out_block_o = out_q;
  assign full_o      = full;
  assign app_ready_o = !full;

  assert_ready_vs_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !app_ready_o);
endmodule

// File: tb/test_migr_queue.sv
`timescale 1ns/1ps
module test_migr_queue;
  localparam int K = 8;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         app_valid = 1'b0, app_dummy = 1'b0, vacancy = 1'b0, slot = 1'b0;
  logic [W-1:0] app_block = '0;
  logic [7:0]   thr = '0;
  logic         app_ready, stash_valid, tree_req, full;
  logic [W-1:0] out_block;
  logic [3:0]   count;

  int n_chk = 0, n_bad = 0, rand_trees = 0;
  logic [W-1:0] mq[$];

  always #2 clk = ~clk;

  migr_queue #(.DEPTH(K), .BLOCK_W(W)) i_migr_queue (
    .clk_i(clk), .rst_ni(rst_ni),
    .app_valid_i(app_valid), .app_dummy_i(app_dummy), .app_block_i(app_block),
    .app_ready_o(app_ready), .vacancy_i(vacancy), .slot_i(slot),
    .prob_thr_i(thr), .stash_valid_o(stash_valid), .tree_req_o(tree_req),
    .out_block_o(out_block), .count_o(count), .full_o(full)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit in_range(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // one cycle: inputs driven at negedge, results sampled at the next negedge
  task automatic cyc(input bit v, input bit d, input logic [W-1:0] b,
                     input bit vac, input bit s, input logic [7:0] t);
    int  cnt;
    bit  real_app, exp_vac, forced, may_rand, exp_enq;
    app_valid = v; app_dummy = d; app_block = b; vacancy = vac; slot = s; thr = t;
    cnt      = mq.size();
    real_app = v && !d;
    exp_vac  = vac && cnt > 0;
    forced   = real_app && cnt == K && !exp_vac;
    may_rand = s && cnt > 0 && !exp_vac && t != 0;
    exp_enq  = real_app && cnt < K;
    @(posedge clk);
    @(negedge clk);
    chk(stash_valid == exp_vac, "R3/R8 stash_valid", stash_valid, exp_vac);
    chk(!(stash_valid && tree_req), "R11 one exit", {stash_valid, tree_req}, 0);
    if (forced)
      chk(tree_req == 1'b1, "R7 forced tree_req", tree_req, 1);
    else if (!may_rand)
      chk(tree_req == 1'b0, "R4 no unexpected tree_req", tree_req, 0);
    else if (tree_req)
      rand_trees++;
    if ((stash_valid || tree_req) && mq.size() > 0) begin
      chk(out_block == mq[0], "R3 head block order", out_block, mq[0]);
      void'(mq.pop_front());
    end
    if (exp_enq) mq.push_back(b);
    chk(count == mq.size(), "R2/R9 count", count, mq.size());
    chk(full == (mq.size() == K), "R6 full", full, mq.size() == K);
    chk(app_ready == (mq.size() != K), "R6 ready", app_ready, mq.size() != K);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base, c0;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(count == 0 && !full && app_ready && !stash_valid && !tree_req,
        "R10 reset", {count, full, app_ready, stash_valid, tree_req}, 4'h0 << 4 | 5'b00100);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 dummy appends on empty queue
    cyc(1, 1, 32'hDEAD0001, 0, 0, 0);
    chk(count == 0, "R1 dummy ignored", count, 0);
    // R3 vacancy on empty queue does nothing
    cyc(0, 0, 0, 1, 0, 0);
    chk(!stash_valid, "R3 empty vacancy", stash_valid, 0);

    // R2 fill to full
    for (int i = 0; i < K; i++) cyc(1, 0, 32'hA000 + i, 0, 0, 0);
    chk(full && count == K, "R6 reached full", count, K);
    // R1 dummy while full: no forced drain, no change
    cyc(1, 1, 32'hDEAD0002, 0, 1, 0);
    chk(count == K && !tree_req, "R1 dummy at full", count, K);
    // R7 real append while full forces drain, retry accepted
    cyc(1, 0, 32'hB001, 0, 0, 0);
    chk(tree_req && out_block == 32'hA000, "R7 forced head", out_block, 32'hA000);
    cyc(1, 0, 32'hB001, 0, 0, 0);
    chk(count == K, "R7 retry accepted", count, K);
    // R8 vacancy together with guaranteed-eligible random slot
    cyc(0, 0, 0, 1, 1, 8'hFF);
    chk(stash_valid && !tree_req && count == K - 1, "R8 vacancy wins", count, K - 1);
    // R9 enqueue and vacancy dequeue together
    c0 = mq.size();
    cyc(1, 0, 32'hC001, 1, 0, 0);
    chk(count == c0, "R9 count held", count, c0);

    // R4 threshold 0: drain never raised over many slots
    base = rand_trees;
    for (int i = 0; i < 200; i++) cyc(0, 0, 0, 0, 1, 0);
    chk(rand_trees == base && count == c0, "R4 thr zero", rand_trees - base, 0);

    // R5 rate: threshold 64 over 1024 nonempty slots
    base = rand_trees;
    for (int i = 0; i < 1024; i++) begin
      bit top_up = (mq.size() < K - 1);
      cyc(top_up, 0, 32'hE000 + i, 0, 1, 8'd64);
    end
    chk(in_range(rand_trees - base, 160, 352), "R5 drain rate", rand_trees - base, 256);

    // drain down via vacancies, order checked in cyc
    while (mq.size() > 0) cyc(0, 0, 0, 1, 0, 0);
    chk(count == 0, "R3 drained", count, 0);

    // mixed random stimulus
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] t;
      int sel = $urandom_range(0, 2);
      t = (sel == 0) ? 8'd0 : (sel == 1) ? 8'd40 : 8'd200;
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0, $urandom,
          $urandom_range(0, 4) == 0, $urandom_range(0, 1) == 1, t);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule